// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block collects up to 32 interrupt lines and reports them to a processor with a memory write instead of an interrupt wire. Every line passes through a synchroniser and a rising-edge detector. A detected edge marks the line in a pending register, whether the line is masked or not. When the line is also enabled in the mask register, the edge marks the line in a request register and asks for one posted write on a bus-master port. The write goes to a programmable target register with its five low bits forced to zero. The write data is those five low bits, zero-extended.

Software reaches five 32-bit registers through a simple slave port with separate read and write strobes. Read data is registered. A bus-error flag in the control register stops new delivery writes and leaves the bookkeeping registers working. The master port holds at most one write. Edges that arrive while that write waits are merged into one follow-up write.

Top module: `msi_irq_ctrl`

Register map (word index on `reg_addr`): 0 request (read-only), 1 mask, 2 pending, 3 control, 4 target. The bus-error flag is bit 0 of the control register.

## Requirements
- R1: After reset, request, mask, pending and control read as zero, target reads 0xFFFB0003, and `m_valid` is low.
- R2: A rising edge on `irq_in[i]` sets pending bit i whether or not mask bit i is set. An input held high updates the registers only once.
- R3: A rising edge on a line whose mask bit is set sets request bit i and asks for exactly one delivery write. Several such edges in the same cycle give a single write.
- R4: A delivery write presents `m_addr` = target with bits 4:0 cleared and `m_data` = target bits 4:0 zero-extended. Both stay stable while `m_valid` is high and `m_ready` is low.
- R5: While control bit 0 (bus error) is set, no new delivery write starts. Pending and request bits still update.
- R6: A read of the pending register (index 2) returns its value and clears it. Any write to it clears it, whatever the data.
- R7: Writes to the request register (index 0) are ignored. Its bits stay set until reset.
- R8: A read of the control register (index 3) returns bit 0 only, with bits 31:1 read as zero.
- R9: The mask (index 1) and target (index 4) registers read back exactly what was written, including all ones.
- R10: A low level, or a falling edge, on an interrupt input changes no register and starts no write.
- R11: Only one write is outstanding. Enabled edges that arrive while it waits cause exactly one more write, which starts in the cycle after the handshake.
- R12: `reg_rdata` shows the addressed register one clock after `reg_rd` is sampled high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_IRQ | Asynchronous interrupt lines, active on rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| m_valid | output | 1 | Delivery write valid |
| m_ready | input | 1 | Delivery write accepted |
| m_addr | output | 32 | Delivery write address |
| m_data | output | 32 | Delivery write data |

## Verification
An interrupt edge driven before clock edge k reaches the pending, request and `m_valid` state at edge k+2, after two synchroniser stages and a history flop. The bench holds each line for four cycles and then lets three more cycles pass before it reads anything. Register reads and writes act on the next edge. The bench drives strobes on the falling edge and samples one falling edge later. Delivery handshakes are counted on falling edges while `m_ready` is held high, and the count is compared with the number of writes the model expects.

// File: rtl/msi_ctl_pkg.sv
// Shared constants for the message-signalled interrupt controller.
// Assumes a word-indexed register port; indices are fixed by software.
package msi_ctl_pkg;
    localparam int REG_AW   = 3;
    localparam int DATA_W   = 32;
    localparam int BERR_BIT = 0;
    localparam int ALIGN_W  = 5;

    typedef enum logic [REG_AW-1:0] {
        RA_REQ  = 3'd0,
        RA_MASK = 3'd1,
        RA_PEND = 3'd2,
        RA_CTRL = 3'd3,
        RA_TGT  = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/irq_edge_detect.sv
// Synchronises NUM_IRQ asynchronous lines through SYNC_STAGES flops and
// emits a one-cycle pulse per line on each rising edge.
// Assumes SYNC_STAGES >= 2 and lines wider than one clock.
module irq_edge_detect #(
    parameter int NUM_IRQ     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [NUM_IRQ-1:0] rise
);
    logic [NUM_IRQ-1:0] sync_q [SYNC_STAGES];
    logic [NUM_IRQ-1:0] prev_q;

    // Shift the lines through the synchroniser chain and keep one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= irq_in;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R2: a line held high produces a pulse on one cycle only.
    p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/msi_regfile.sv
// Register set: request, mask, pending, control (bus-error bit) and target.
// Turns edge pulses into pending/request updates and a delivery request.
// Assumes reg_rd and reg_wr are not both set for the same index.
module msi_regfile
    import msi_ctl_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter logic [31:0] RESET_TGT = 32'hFFFB_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_IRQ-1:0] rise,
    output logic               berr,
    output logic [DATA_W-1:0]  tgt,
    output logic               deliv_req
);
    logic [NUM_IRQ-1:0] req_q, mask_q, pend_q;
    logic               berr_q;
    logic [DATA_W-1:0]  tgt_q, rd_mux;
    logic [NUM_IRQ-1:0] hit;
    logic               pend_acc;

    assign hit       = rise & mask_q;
    assign deliv_req = (|hit) && !berr_q;
    assign pend_acc  = (reg_rd || reg_wr) && (reg_addr == RA_PEND);
    assign berr      = berr_q;
    assign tgt       = tgt_q;

    // Pick the addressed register, zero-extended to the bus width.
    always_comb begin
        rd_mux = '0;
        case (reg_idx_e'(reg_addr))
            RA_REQ:  rd_mux[NUM_IRQ-1:0] = req_q;
            RA_MASK: rd_mux[NUM_IRQ-1:0] = mask_q;
            RA_PEND: rd_mux[NUM_IRQ-1:0] = pend_q;
            RA_CTRL: rd_mux[BERR_BIT]    = berr_q;
            RA_TGT:  rd_mux              = tgt_q;
            default: rd_mux              = '0;
        endcase
    end

    // Pending: cleared by any access, new edges in the same cycle survive.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_acc) pend_q <= rise;
        else               pend_q <= pend_q | rise;
    end

    // Request: set by enabled edges only, never cleared by the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_q | hit;
    end

    // Plain read/write storage for mask, control flag and target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            berr_q <= 1'b0;
            tgt_q  <= RESET_TGT;
        end else if (reg_wr) begin
            case (reg_idx_e'(reg_addr))
                RA_MASK: mask_q <= reg_wdata[NUM_IRQ-1:0];
                RA_CTRL: berr_q <= reg_wdata[BERR_BIT];
                RA_TGT:  tgt_q  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R7: request bits are never cleared after reset.
    p_req_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~req_q & $past(req_q)) == '0));
    // R6: an access with no new edge leaves pending empty.
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_acc && rise == '0) |=> (pend_q == '0));
    // R2: every edge lands in pending on the next cycle.
    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/msi_deliver.sv
// Single-entry posted-write master. Loads address and data from the target
// register at launch and merges requests seen while busy into one flag.
// Assumes the slave may hold m_ready low for any number of cycles.
module msi_deliver
    import msi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] tgt,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data
);
    logic extra_q, launch;

    assign launch = (!m_valid && req) || (m_valid && m_ready && (extra_q || req));

    // Launch, retire or merge one delivery write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            extra_q <= 1'b0;
            m_addr  <= '0;
            m_data  <= '0;
        end else if (launch) begin
            m_valid <= 1'b1;
            extra_q <= 1'b0;
            m_addr  <= {tgt[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
            m_data  <= {{(DATA_W-ALIGN_W){1'b0}}, tgt[ALIGN_W-1:0]};
        end else if (m_valid && m_ready) begin
            m_valid <= 1'b0;
        end else if (m_valid && req) begin
            extra_q <= 1'b1;
        end
    end

    // R4: a stalled write keeps its address and data.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)));
    // R11: a write still waiting for the slave never drops.
    p_no_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> m_valid);
endmodule

// File: rtl/msi_irq_ctrl.sv
// Top level: edge detection, register set and delivery master.
// Assumes irq_in lines are asynchronous and stay at each level for at least
// SYNC_STAGES+1 cycles.
module msi_irq_ctrl
    import msi_ctl_pkg::*;
#(
    parameter int          NUM_IRQ     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] RESET_TGT   = 32'hFFFB_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [31:0]        m_addr,
    output logic [31:0]        m_data
);
    logic [NUM_IRQ-1:0] rise;
    logic               berr, deliv_req;
    logic [DATA_W-1:0]  tgt;

    irq_edge_detect #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
    );

    msi_regfile #(.NUM_IRQ(NUM_IRQ), .RESET_TGT(RESET_TGT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rise(rise), .berr(berr), .tgt(tgt), .deliv_req(deliv_req)
    );

    msi_deliver u_dlv (
        .clk(clk), .rst_n(rst_n), .req(deliv_req), .tgt(tgt),
        .m_ready(m_ready), .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data)
    );

    // R5: with the bus-error flag set, an idle master stays idle.
    p_berr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid && berr) |=> !m_valid);
    // R4: delivery data never carries bits above the alignment field.
    p_data_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_data[31:ALIGN_W] == '0 && m_addr[ALIGN_W-1:0] == '0));
endmodule

// File: tb/msi_irq_ctrl_tb_top.sv
module msi_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        m_valid, m_ready = 1'b0;
    logic [31:0] m_addr, m_data;

    int vectors = 0, miscomp = 0;
    int exp_deliv = 0, seen_deliv = 0;
    bit mon_en = 1'b0;
    logic [31:0] md_req = '0, md_mask = '0, md_pend = '0, md_ctrl = '0, md_tgt = 32'hFFFB_0003;

    always #5 clk = ~clk;

    msi_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] t);
        return {t[31:5], 5'b0};
    endfunction
    function automatic logic [31:0] exp_data(input logic [31:0] t);
        return {27'b0, t[4:0]};
    endfunction
    function automatic logic [31:0] model_read(input int a);
        case (a)
            0: return md_req;
            1: return md_mask;
            2: return md_pend;
            3: return {31'b0, md_ctrl[0]};
            4: return md_tgt;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            1: md_mask = d;
            2: md_pend = '0;
            3: md_ctrl = d;
            4: md_tgt  = d;
            default: ;
        endcase
    endtask

    // R12: data is sampled one falling edge after the strobe's clock edge.
    task automatic rd_chk(input int a, input string tag);
        logic [31:0] e;
        e = model_read(a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        chk(reg_rdata === e, tag, reg_rdata, e);
        if (a == 2) md_pend = '0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        md_pend |= v;
        md_req  |= v & md_mask;
        if ((v & md_mask) != 0 && !md_ctrl[0]) exp_deliv++;
        repeat (4) @(negedge clk);
        irq_in = '0;
        repeat (3) @(negedge clk);
    endtask

    // Delivery monitor, used only while m_ready is held high.
    always @(negedge clk) begin
        if (mon_en && rst_n && m_valid && m_ready) begin
            seen_deliv++;
            chk(m_addr === exp_addr(md_tgt), "R4 addr", m_addr, exp_addr(md_tgt));
            chk(m_data === exp_data(md_tgt), "R4 data", m_data, exp_data(md_tgt));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        logic [31:0] a0, d0;
        int base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(m_valid === 1'b0, "R1 m_valid", {31'b0, m_valid}, 32'd0);
        for (int a = 0; a < 5; a++) rd_chk(a, "R1 reset read");

        // R10 and R2: masked edge sets pending only, nothing is sent
        pulse(32'h0000_0041);
        chk(m_valid === 1'b0, "R10 no write when masked", {31'b0, m_valid}, 32'd0);
        rd_chk(0, "R2 request untouched by masked edge");
        rd_chk(2, "R2 pending set while masked");
        rd_chk(2, "R6 pending cleared by read");

        // R9 plain registers
        wr(1, 32'hFFFF_FFFF);
        rd_chk(1, "R9 mask all ones");
        wr(4, 32'h1234_5677);
        rd_chk(4, "R9 target");

        // R3, R4, R11 with the slave stalled
        pulse(32'h0000_0005);
        chk(m_valid === 1'b1, "R3 one write", {31'b0, m_valid}, 32'd1);
        chk(m_addr === 32'h1234_5660, "R4 aligned addr", m_addr, 32'h1234_5660);
        chk(m_data === 32'h0000_0017, "R4 low bits data", m_data, 32'h0000_0017);
        pulse(32'h0000_0100);
        chk(m_valid === 1'b1 && m_addr === 32'h1234_5660, "R11 held while busy", m_addr, 32'h1234_5660);
        m_ready = 1'b1;
        @(negedge clk);
        chk(m_valid === 1'b1, "R11 merged follow-up", {31'b0, m_valid}, 32'd1);
        @(negedge clk);
        chk(m_valid === 1'b0, "R11 only one follow-up", {31'b0, m_valid}, 32'd0);
        m_ready = 1'b0;
        rd_chk(0, "R3 request bits");

        // R7 request writes ignored
        wr(0, 32'h0000_0000);
        rd_chk(0, "R7 request after write");

        // R8 and R5 bus error
        wr(3, 32'hFFFF_FFFF);
        rd_chk(3, "R8 control reads bit 0 only");
        pulse(32'h0000_0200);
        chk(m_valid === 1'b0, "R5 no write on bus error", {31'b0, m_valid}, 32'd0);
        rd_chk(0, "R5 request still set");
        wr(3, 32'h0000_0000);
        rd_chk(2, "R5 pending still set");

        // R6 write clears pending whatever the data
        pulse(32'h0000_0030);
        wr(2, 32'h0000_00A5);
        rd_chk(2, "R6 pending cleared by write");

        // From here the slave is always ready and handshakes are counted
        m_ready = 1'b1;
        repeat (2) @(negedge clk);
        exp_deliv = 0; seen_deliv = 0; mon_en = 1'b1;

        // R2 held input updates once
        irq_in = 32'h0000_0008;
        md_pend |= 32'h8; md_req |= 32'h8; exp_deliv++;
        repeat (6) @(negedge clk);
        rd_chk(2, "R2 held input pending");
        repeat (6) @(negedge clk);
        rd_chk(2, "R2 held input no repeat");
        chk(seen_deliv == 1, "R2 held input single write", 32'(seen_deliv), 32'd1);
        irq_in = '0;
        repeat (4) @(negedge clk);
        rd_chk(2, "R10 falling edge no effect");

        // Constrained random phase
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom % 9);
            case (op)
                0, 1, 2: begin
                    d0 = $urandom;
                    if ($urandom % 3 == 0) d0 = d0 & $urandom & $urandom;
                    pulse(d0);
                end
                3: wr(1, ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom);
                4: wr(3, ($urandom % 4 == 0) ? ($urandom | 32'h1) : ($urandom & ~32'h1));
                5: wr(4, $urandom);
                6: begin
                    a0 = $urandom % 5;
                    rd_chk(int'(a0), "R6-R9 random read");
                end
                7: wr(2, $urandom);
                default: wr(0, $urandom);
            endcase
        end
        repeat (4) @(negedge clk);
        chk(seen_deliv == exp_deliv, "R3 delivery count", 32'(seen_deliv), 32'(exp_deliv));
        for (int a = 0; a < 5; a++) rd_chk(a, "R7 final register state");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule